// File: doc/BRIEF.md
# SPI Slave Register Access Controller

This block lets a host processor reach a bank of 32-bit control and status registers over a four-wire serial link. The host pulls chip select low. It then clocks in an 8-bit instruction, and after that an 8-bit field that names a DWORD. One or more 32-bit data words follow. Every field moves most-significant bit first. On the other side the block drives a simple synchronous register bus. That bus carries a byte address, write data, a one-cycle write strobe and a one-cycle read strobe. Read data is returned combinationally in the same cycle as the read strobe.

A transfer reads or writes either one word or a burst. In a burst the DWORD address steps up, steps down, or stays fixed for every word. The serial pins pass through two-flop synchronizers into the system clock. All work is done in the system clock domain. The system clock must run at least four times faster than the serial clock. The block responds only when its management-mode input selects serial management.

Top module: `spi_csr_bridge`

## Requirements
- R1: The block reacts only while `modeSel` equals 2'b11. With any other value it issues no bus strobes and keeps `soEn` low.
- R2: While `csN` is high, `si` and `sck` have no effect and `soEn` is low within three clock cycles. While `csN` is low and the mode is enabled, `soEn` is high.
- R3: `si` is sampled on rising `sck` edges. The first 8 bits after `csN` falls form the instruction and the next 8 bits form the DWORD address. Each bus access uses byte address {dword, 2'b00}.
- R4: Bit 0 of the instruction selects read (1) or write (0). Bits [4:3] select the step mode: 00 single word, 01 increment, 10 decrement, 11 fixed. Valid codes are therefore 0x02, 0x03, 0x0A, 0x0B, 0x12, 0x13, 0x1A and 0x1B.
- R5: Any other instruction code causes no bus access and leaves `so` at 0 until `csN` rises.
- R6: A write issues one `regWe` pulse carrying the 32-bit word only after all 32 of its bits have arrived, assembled MSB first. A partial word is dropped when `csN` rises.
- R7: A read issues `regRe` once the last address bit is sampled. The word is shifted out on `so`, MSB first, changing after falling `sck` edges, and its first bit is valid before the first rising edge after the address.
- R8: In a burst, each word after the first goes to the DWORD address plus 1, minus 1, or unchanged, according to the step mode. The address wraps modulo 256.
- R9: A single-word instruction transfers exactly one word. Further clocks in the same selection are ignored.
- R10: A burst read fetches each next word while the last bit of the current word goes out. A burst of N words therefore issues N+1 read strobes.
- R11: A rise of `csN` returns the block to idle at any point, so the next selection always begins with a fresh instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 2 | Management mode; 2'b11 enables the block |
| sck | input | 1 | Serial clock from the host |
| csN | input | 1 | Active-low chip select |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| soEn | output | 1 | Output enable for the `so` pad driver |
| regAddr | output | 10 | Register byte address, low two bits zero |
| regWdata | output | 32 | Register write data |
| regWe | output | 1 | One-cycle register write strobe |
| regRe | output | 1 | One-cycle register read strobe |
| regRdata | input | 32 | Register read data, valid while `regRe` is high |

## Verification
All eight valid instructions are driven at the base addresses 0x00, 0x01, 0x7F and 0xFF, each with three data words. This separates the step modes from one another. It also exposes wrap-around at both ends of the address space and shows that single-word codes stop after one word. The read data is a function of the address, so a wrong fetch address or a byte-order fault shows up as a wrong word. A spread of invalid instruction codes confirms that nothing decodes too loosely. Separate runs with chip select high, with the mode disabled, and with a write cut short check the idle and abort paths.

// File: rtl/spi_csr_pkg.sv
package spi_csr_pkg;

  // Step mode carried in instruction bits [4:3].
  typedef enum logic [1:0] {
    BURST_NONE = 2'b00,
    BURST_UP   = 2'b01,
    BURST_DOWN = 2'b10,
    BURST_HOLD = 2'b11
  } burst_e;

  // Strobes from control to datapath.
  typedef struct packed {
    logic   shiftIn;
    logic   latchAddr;
    logic   fetchFirst;
    logic   fetchNext;
    logic   writeWord;
    logic   shiftOut;
    burst_e burst;
  } strobe_t;

  localparam logic [1:0] MODE_SERIAL = 2'b11;

  // Valid codes: 000b_b01b
  function automatic logic opValid(input logic [7:0] op);
    return (op[7:5] == 3'b000) && (op[2:1] == 2'b01);
  endfunction

endpackage

// File: rtl/spi_csr_datapath.sv
module spi_csr_datapath
  import spi_csr_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic              sck,
  input  logic              csN,
  input  logic              si,
  input  strobe_t           strb,
  output logic              sckRise,
  output logic              sckFall,
  output logic              csLive,
  output logic [7:0]        opByte,
  output logic              so,
  output logic              soEn,
  output logic [ADDR_W+1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWe,
  output logic              regRe,
  input  logic [DATA_W-1:0] regRdata
);

  localparam int           N_SYNC    = 3;
  localparam logic [2:0]   SYNC_INIT = 3'b100;  // {csN, si, sck}

  logic [N_SYNC-1:0] rawIn;
  logic [N_SYNC-1:0] synced;
  assign rawIn = {csN, si, sck};

  for (genvar g = 0; g < N_SYNC; g++) begin : gSync
    logic [SYNC_STAGES-1:0] stg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stg <= {SYNC_STAGES{SYNC_INIT[g]}};
      else       stg <= {stg[SYNC_STAGES-2:0], rawIn[g]};
    end
    assign synced[g] = stg[SYNC_STAGES-1];
  end

  logic sckS, siS, csS, sckPrev;
  assign sckS = synced[0];
  assign siS  = synced[1];
  assign csS  = synced[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sckPrev <= 1'b0;
    else       sckPrev <= sckS;
  end

  assign sckRise = sckS & ~sckPrev;
  assign sckFall = ~sckS & sckPrev;
  assign csLive  = ~csS & (modeSel == MODE_SERIAL);

  // Receive shifter
  logic [DATA_W-2:0] rxShift;
  logic [DATA_W-1:0] rxNext;
  assign rxNext = {rxShift, siS};
  assign opByte = rxNext[7:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             rxShift <= '0;
    else if (strb.shiftIn) rxShift <= rxNext[DATA_W-2:0];
  end

  // DWORD address stepping
  logic [ADDR_W-1:0] dwAddr, stepped;
  always_comb begin
    case (strb.burst)
      BURST_UP:   stepped = dwAddr + ADDR_W'(1);
      BURST_DOWN: stepped = dwAddr - ADDR_W'(1);
      default:    stepped = dwAddr;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dwAddr   <= '0;
      regAddr  <= '0;
      regWdata <= '0;
      regWe    <= 1'b0;
      regRe    <= 1'b0;
    end else begin
      regWe <= 1'b0;
      regRe <= 1'b0;
      if (strb.latchAddr) dwAddr <= rxNext[ADDR_W-1:0];
      if (strb.fetchFirst) begin
        regAddr <= {rxNext[ADDR_W-1:0], 2'b00};
        regRe   <= 1'b1;
      end
      if (strb.fetchNext) begin
        dwAddr  <= stepped;
        regAddr <= {stepped, 2'b00};
        regRe   <= 1'b1;
      end
      if (strb.writeWord) begin
        regWdata <= rxNext;
        regAddr  <= {dwAddr, 2'b00};
        regWe    <= 1'b1;
        dwAddr   <= stepped;
      end
    end
  end

  // Transmit shifter
  logic [DATA_W-1:0] txReg;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg <= '0;
      so    <= 1'b0;
      soEn  <= 1'b0;
    end else begin
      soEn <= csLive;
      if (!csLive) begin
        txReg <= '0;
        so    <= 1'b0;
      end else if (regRe) begin
        txReg <= regRdata;
      end else if (strb.shiftOut) begin
        so    <= txReg[DATA_W-1];
        txReg <= {txReg[DATA_W-2:0], 1'b0};
      end
    end
  end

endmodule

// File: rtl/spi_csr_ctrl.sv
module spi_csr_ctrl
  import spi_csr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sckRise,
  input  logic       sckFall,
  input  logic       csLive,
  input  logic [7:0] opByte,
  output strobe_t    strb
);

  localparam int              CNT_W    = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] BYTE_END = CNT_W'(7);
  localparam logic [CNT_W-1:0] WORD_END = CNT_W'(DATA_W - 1);

  typedef enum logic [1:0] {S_CMD, S_ADDR, S_DATA, S_DROP} state_e;

  state_e           state;
  logic [CNT_W-1:0] bitCnt, txCnt;
  logic             isRead;
  burst_e           burst;

  always_comb begin
    strb       = '0;
    strb.burst = burst;
    if (csLive) begin
      case (state)
        S_CMD:  strb.shiftIn = sckRise;
        S_ADDR: begin
          strb.shiftIn = sckRise;
          if (sckRise && bitCnt == BYTE_END) begin
            strb.latchAddr  = 1'b1;
            strb.fetchFirst = isRead;
          end
        end
        S_DATA: begin
          if (isRead) begin
            strb.shiftOut  = sckFall;
            strb.fetchNext = sckFall && txCnt == WORD_END && burst != BURST_NONE;
          end else begin
            strb.shiftIn   = sckRise;
            strb.writeWord = sckRise && bitCnt == WORD_END;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= S_CMD;
      bitCnt <= '0;
      txCnt  <= '0;
      isRead <= 1'b0;
      burst  <= BURST_NONE;
    end else if (!csLive) begin
      state  <= S_CMD;
      bitCnt <= '0;
      txCnt  <= '0;
      isRead <= 1'b0;
      burst  <= BURST_NONE;
    end else begin
      case (state)
        S_CMD: if (sckRise) begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == BYTE_END) begin
            bitCnt <= '0;
            if (opValid(opByte)) begin
              state  <= S_ADDR;
              isRead <= opByte[0];
              burst  <= burst_e'(opByte[4:3]);
            end else begin
              state <= S_DROP;
            end
          end
        end
        S_ADDR: if (sckRise) begin
          bitCnt <= bitCnt + 1'b1;
          if (bitCnt == BYTE_END) begin
            bitCnt <= '0;
            state  <= S_DATA;
          end
        end
        S_DATA: begin
          if (isRead) begin
            if (sckFall) begin
              txCnt <= txCnt + 1'b1;
              if (txCnt == WORD_END) begin
                txCnt <= '0;
                if (burst == BURST_NONE) state <= S_DROP;
              end
            end
          end else if (sckRise) begin
            bitCnt <= bitCnt + 1'b1;
            if (bitCnt == WORD_END) begin
              bitCnt <= '0;
              if (burst == BURST_NONE) state <= S_DROP;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/spi_csr_bridge.sv
module spi_csr_bridge
  import spi_csr_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        modeSel,
  input  logic              sck,
  input  logic              csN,
  input  logic              si,
  output logic              so,
  output logic              soEn,
  output logic [ADDR_W+1:0] regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              regWe,
  output logic              regRe,
  input  logic [DATA_W-1:0] regRdata
);

  strobe_t    strb;
  logic       sckRise, sckFall, csLive;
  logic [7:0] opByte;

  spi_csr_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .sckRise(sckRise), .sckFall(sckFall),
    .csLive(csLive), .opByte(opByte), .strb(strb)
  );

  spi_csr_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .sck(sck), .csN(csN), .si(si),
    .strb(strb), .sckRise(sckRise), .sckFall(sckFall), .csLive(csLive),
    .opByte(opByte), .so(so), .soEn(soEn), .regAddr(regAddr),
    .regWdata(regWdata), .regWe(regWe), .regRe(regRe), .regRdata(regRdata)
  );

endmodule

// File: rtl/spi_csr_checker.sv
module spi_csr_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        modeSel,
  input logic              csN,
  input logic              soEn,
  input logic [ADDR_W+1:0] regAddr,
  input logic              regWe,
  input logic              regRe
);

  // R1: disabled mode stays silent
  a_r1_mode_off_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != 2'b11 && $past(modeSel) != 2'b11 && $past(modeSel, 2) != 2'b11)
    |-> (!regWe && !regRe && !soEn));

  // R2: deselected block neither drives nor accesses
  a_r2_cs_high_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3))
    |-> (!soEn && !regWe && !regRe));

  // R3: bus accesses are DWORD aligned
  a_r3_dword_aligned: assert property (@(posedge clk) disable iff (!rstN)
    (regWe || regRe) |-> (regAddr[1:0] == 2'b00));

  // R6: write strobe is a single-cycle pulse
  a_r6_we_pulse: assert property (@(posedge clk) disable iff (!rstN)
    regWe |=> !regWe);

  // R10: read strobe is a single-cycle pulse, never with a write
  a_r10_re_pulse: assert property (@(posedge clk) disable iff (!rstN)
    regRe |=> (!regRe && !regWe));

endmodule

bind spi_csr_bridge spi_csr_checker #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .csN(csN), .soEn(soEn),
  .regAddr(regAddr), .regWe(regWe), .regRe(regRe)
);

// File: tb/spi_csr_bridge_tb_top.sv
module spi_csr_bridge_tb_top;

  localparam int HALF = 6;
  localparam int NW   = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  modeSel = 2'b11;
  logic        sck = 1'b0;
  logic        csN = 1'b1;
  logic        si = 1'b0;
  logic        so, soEn, regWe, regRe;
  logic [9:0]  regAddr;
  logic [31:0] regWdata, regRdata;

  logic [31:0] mem [256];
  int          weCnt = 0, reCnt = 0;
  logic [9:0]  weAddrLog [8];
  logic [31:0] weDataLog [8];
  int          total = 0, failCnt = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  spi_csr_bridge dut_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .sck(sck), .csN(csN), .si(si),
    .so(so), .soEn(soEn), .regAddr(regAddr), .regWdata(regWdata),
    .regWe(regWe), .regRe(regRe), .regRdata(regRdata)
  );

  assign regRdata = mem[regAddr[9:2]];

  always @(posedge clk) begin
    if (regWe) begin
      mem[regAddr[9:2]] <= regWdata;
      if (weCnt < 8) begin
        weAddrLog[weCnt] <= regAddr;
        weDataLog[weCnt] <= regWdata;
      end
      weCnt <= weCnt + 1;
    end
    if (regRe) reCnt <= reCnt + 1;
  end

  function automatic logic [31:0] pat(input logic [7:0] a);
    return {a, ~a, a ^ 8'h5A, 8'hC3};
  endfunction

  function automatic logic [7:0] stepOf(input logic [7:0] op);
    case (op[4:3])
      2'b01:   return 8'h01;
      2'b10:   return 8'hFF;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit isValidOp(input logic [7:0] op);
    case (op)
      8'h02, 8'h03, 8'h0A, 8'h0B, 8'h12, 8'h13, 8'h1A, 8'h1B: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic preload();
    for (int i = 0; i < 256; i++) mem[i] = pat(8'(i));
  endtask

  task automatic clearLogs();
    @(negedge clk);
    weCnt = 0;
    reCnt = 0;
  endtask

  task automatic sBit(input logic b, output logic got);
    si = b;
    repeat (HALF) @(negedge clk);
    got = so;
    sck = 1'b1;
    repeat (HALF) @(negedge clk);
    sck = 1'b0;
  endtask

  task automatic sByte(input logic [7:0] v);
    logic g;
    for (int i = 7; i >= 0; i--) sBit(v[i], g);
  endtask

  task automatic sWord(input logic [31:0] v, output logic [31:0] got);
    logic g;
    for (int i = 31; i >= 0; i--) begin
      sBit(v[i], g);
      got[i] = g;
    end
  endtask

  task automatic csStart();
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic csEnd();
    repeat (HALF) @(negedge clk);
    csN = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", total - failCnt, total);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++;
      failCnt++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      finishRun();
    end
  end

  initial begin
    logic [31:0] got;
    logic [7:0]  ops [8];
    logic [7:0]  bases [4];
    ops   = '{8'h03, 8'h02, 8'h0B, 8'h0A, 8'h13, 8'h12, 8'h1B, 8'h1A};
    bases = '{8'h00, 8'h01, 8'h7F, 8'hFF};
    preload();
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // Reset state
    chk(soEn == 1'b0, "R2 reset soEn", 32'(soEn), 0);
    chk(regWe == 1'b0 && regRe == 1'b0, "R6 reset strobes", {regWe, regRe}, 0);

    // Sweep of valid instructions
    for (int o = 0; o < 8; o++) begin
      for (int b = 0; b < 4; b++) begin
        logic [7:0] op, base, st;
        int expWords;
        op = ops[o];
        base = bases[b];
        st = stepOf(op);
        expWords = (op[4:3] == 2'b00) ? 1 : NW;
        preload();
        clearLogs();
        csStart();
        sByte(op);
        chk(soEn == 1'b1, "R2 soEn while selected", 32'(soEn), 1);
        sByte(base);
        if (op[0]) begin
          for (int k = 0; k < NW; k++) begin
            logic [7:0] ea;
            sWord(32'h0, got);
            ea = base + 8'(k) * st;
            if (k < expWords)
              chk(got == pat(ea), "R7 R8 read word", got, pat(ea));
          end
          csEnd();
          chk(reCnt == ((expWords == 1) ? 1 : NW + 1), "R10 R9 read strobe count",
              32'(reCnt), 32'((expWords == 1) ? 1 : NW + 1));
          chk(weCnt == 0, "R4 read makes no write", 32'(weCnt), 0);
        end else begin
          for (int k = 0; k < NW; k++)
            sWord({op, base, 8'(k), 8'hA5}, got);
          csEnd();
          chk(weCnt == expWords, "R9 R6 write count", 32'(weCnt), 32'(expWords));
          chk(reCnt == 0, "R4 write makes no read", 32'(reCnt), 0);
          for (int k = 0; k < expWords && k < 8; k++) begin
            logic [7:0] ea;
            ea = base + 8'(k) * st;
            chk(weAddrLog[k] == {ea, 2'b00}, "R3 R8 write address", 32'(weAddrLog[k]), 32'({ea, 2'b00}));
            chk(weDataLog[k] == {op, base, 8'(k), 8'hA5}, "R6 write data", weDataLog[k], {op, base, 8'(k), 8'hA5});
          end
        end
      end
    end

    // Invalid instruction codes
    for (int op = 0; op < 256; op += 3) begin
      if (!isValidOp(8'(op))) begin
        clearLogs();
        csStart();
        sByte(8'(op));
        sByte(8'h10);
        sWord(32'hFFFF_FFFF, got);
        csEnd();
        chk(weCnt == 0 && reCnt == 0, "R5 invalid code no access", 32'(weCnt + reCnt), 0);
        chk(got == 32'h0, "R5 invalid code so idle", got, 0);
      end
    end

    // Mode disabled
    modeSel = 2'b01;
    repeat (4) @(negedge clk);
    clearLogs();
    csStart();
    sByte(8'h02);
    chk(soEn == 1'b0, "R1 soEn off when disabled", 32'(soEn), 0);
    sByte(8'h20);
    sWord(32'hDEAD_BEEF, got);
    csEnd();
    chk(weCnt == 0 && reCnt == 0, "R1 no access when disabled", 32'(weCnt + reCnt), 0);
    modeSel = 2'b11;
    repeat (4) @(negedge clk);

    // Activity with chip select high
    clearLogs();
    for (int i = 0; i < 48; i++) begin
      logic g;
      sBit(i[0] ^ i[2], g);
    end
    chk(weCnt == 0 && reCnt == 0, "R2 sck ignored when deselected", 32'(weCnt + reCnt), 0);
    chk(soEn == 1'b0, "R2 soEn low when deselected", 32'(soEn), 0);

    // Partial word dropped, then fresh transaction
    clearLogs();
    csStart();
    sByte(8'h0A);
    sByte(8'h30);
    sWord(32'h1234_5678, got);
    for (int i = 0; i < 10; i++) begin
      logic g;
      sBit(1'b1, g);
    end
    csEnd();
    chk(weCnt == 1, "R6 partial word dropped", 32'(weCnt), 1);
    chk(weDataLog[0] == 32'h1234_5678, "R6 full word kept", weDataLog[0], 32'h1234_5678);
    clearLogs();
    csStart();
    sByte(8'h02);
    sByte(8'h31);
    sWord(32'hCAFE_F00D, got);
    csEnd();
    chk(weCnt == 1 && weAddrLog[0] == {8'h31, 2'b00}, "R11 fresh start address",
        32'(weAddrLog[0]), 32'({8'h31, 2'b00}));
    chk(weDataLog[0] == 32'hCAFE_F00D, "R11 fresh start data", weDataLog[0], 32'hCAFE_F00D);

    done = 1'b1;
    finishRun();
  end

endmodule